// File: doc/BRIEF.md
# Serial Configuration Packet Receiver

This block takes configuration settings for one four-channel neural recording module from a shared serial line. A programming data pin is sampled on every rising edge of a programming clock, and each bit slides into a packet-wide shift register. On every clock the oldest 21 bits in that register are compared with a fixed 13-bit start pattern and with this module's own 8-bit address. When both match, the full packet is aligned in the register. On the next clock the 35 payload bits are copied into holding registers in a single step, and a one-cycle notification pulse is raised.

The held settings give, for each channel, a front-end bias code, a gain code, and a recording-mode bit. One comparator bias trim code is shared by the module. Each gain code is also decoded into a one-hot vector that picks exactly one of eight gain-network switches. Several modules can sit on the same data and clock lines. Each one accepts only the packets that carry its address.

The serial input is a plain sampled pin with no valid/ready handshake. The sender owns the pace of the clock, and the receiver cannot apply back-pressure. Every rising edge shifts one bit in, so a bit that is not wanted must not be clocked in.

Top module: `cfg_pkt_rx`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released until the first accepted packet, the outputs hold their defaults. These are bias code 4'b1000 per channel, gain code 0 per channel (switch select 8'b00000001), recording-mode bit 1 (spike) per channel, trim code 3'b100, and no update pulse.
- R2: Bits enter MSB first. The first 13 bits are the start pattern, the next 8 bits are the address, and the last 35 bits are the payload. In payload bit numbering (34 first in time, 0 last), channel c takes bits [34-8c : 27-8c] as bias[3:0], gain[2:0], mode. The trim code is bits [2:0]. A mode bit of 1 means spike recording and 0 means LFP recording. Output vectors are packed with channel c at `fe_bias[4c+3:4c]`, `pga_gain[3c+2:3c]`, `rec_spike[c]` and `pga_sw_sel[8c+7:8c]`.
- R3: The held outputs change, and `cfg_updated` is high, in exactly the clock cycle after the rising edge that shifts in the 56th bit of an accepted packet. The pulse lasts one cycle.
- R4: A packet whose address differs from the `MOD_ADDR` parameter (default 8'h2A) leaves every output unchanged and raises no pulse.
- R5: A packet whose start pattern differs from 13'b1111100110101 in any bit leaves every output unchanged and raises no pulse.
- R6: For every channel, at all times, `pga_sw_sel` has exactly one bit set, at the index equal to that channel's gain code.
- R7: The held outputs change only in a cycle where `cfg_updated` is high.
- R8: Packets are found at any bit offset. Arbitrary leading bits, even bits that look like part of a start pattern, do not stop a following packet from being accepted. Two packets sent with no gap are each accepted.
- R9: A reset applied in the middle of a packet discards the bits received so far, restores the R1 defaults, and keeps the rest of that packet from being accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prog_clk | input | 1 | Programming clock; bits are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_din | input | 1 | Serial programming data, MSB first |
| fe_bias | output | 16 | Per-channel front-end bias codes, 4 bits per channel |
| pga_gain | output | 12 | Per-channel gain codes, 3 bits per channel |
| rec_spike | output | 4 | Per-channel mode bit: 1 = spike, 0 = LFP |
| pga_sw_sel | output | 32 | Per-channel one-hot gain switch select, 8 bits per channel |
| cmp_trim | output | 3 | Comparator preamplifier bias trim code |
| cfg_updated | output | 1 | One-cycle pulse when a new payload is committed |

## Verification
On every cycle, the bound checker confirms several properties. Each gain decode is one-hot at the index of its code. The held fields stay still except on an update pulse, and the pulse never lasts two cycles. The checker also keeps its own history of the serial pin. From that history it requires that a pulse occurs exactly when a matching start pattern and address were aligned one clock earlier, and that the committed fields equal the payload bits in that history. Some behaviour shows up only in the bench's scenarios: the reset defaults, rejection of packets with a foreign address or a damaged start pattern, a decoy prefix, back-to-back packets, and a reset in the middle of a packet.

// File: rtl/cfgrx_pkg.sv
package cfgrx_pkg;

  typedef enum logic {
    MODE_LFP   = 1'b0,
    MODE_SPIKE = 1'b1
  } rec_mode_e;

  localparam int unsigned DEF_HDR_W  = 13;
  localparam logic [DEF_HDR_W-1:0] DEF_HDR_PAT = 13'b1111100110101;
  localparam int unsigned DEF_ADDR_W = 8;

  // mid-scale value of a code of the given width
  function automatic int unsigned mid_code(input int unsigned w);
    return 1 << (w - 1);
  endfunction

endpackage

// File: rtl/cfgrx_shift.sv
module cfgrx_shift #(
  parameter int unsigned WIDTH = 56
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [WIDTH-1:0] sr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[WIDTH-2:0], din};
  end

endmodule

// File: rtl/cfgrx_frame_det.sv
module cfgrx_frame_det #(
  parameter int unsigned      HDR_W    = 13,
  parameter int unsigned      ADDR_W   = 8,
  parameter logic [HDR_W-1:0] HDR_PAT  = 13'b1111100110101,
  parameter logic [ADDR_W-1:0] MOD_ADDR = 8'h2A,
  localparam int unsigned     TAG_W    = HDR_W + ADDR_W
) (
  input  logic [TAG_W-1:0] tag_bits,
  output logic             hit
);

  logic hdr_ok;
  logic addr_ok;

  assign hdr_ok  = (tag_bits[TAG_W-1 -: HDR_W] == HDR_PAT);
  assign addr_ok = (tag_bits[ADDR_W-1:0] == MOD_ADDR);
  assign hit     = hdr_ok & addr_ok;

endmodule

// File: rtl/cfgrx_hold.sv
module cfgrx_hold #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned BIAS_W = 4,
  parameter int unsigned GAIN_W = 3,
  parameter int unsigned TRIM_W = 3,
  localparam int unsigned CH_W  = BIAS_W + GAIN_W + 1,
  localparam int unsigned PAY_W = NUM_CH * CH_W + TRIM_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  logic [PAY_W-1:0]           payload,
  output logic [NUM_CH*BIAS_W-1:0]   bias,
  output logic [NUM_CH*GAIN_W-1:0]   gain,
  output logic [NUM_CH-1:0]          mode,
  output logic [TRIM_W-1:0]          trim,
  output logic                       updated
);

  localparam logic [BIAS_W-1:0] BIAS_DEF = BIAS_W'(cfgrx_pkg::mid_code(BIAS_W));
  localparam logic [TRIM_W-1:0] TRIM_DEF = TRIM_W'(cfgrx_pkg::mid_code(TRIM_W));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CH_W-1:0]   fld;
    logic [BIAS_W-1:0] bias_q;
    logic [GAIN_W-1:0] gain_q;
    logic              mode_q;

    // channel 0 sits at the most significant end of the payload
    assign fld = payload[PAY_W-1-c*CH_W -: CH_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bias_q <= BIAS_DEF;
        gain_q <= '0;
        mode_q <= cfgrx_pkg::MODE_SPIKE;
      end else if (commit) begin
        bias_q <= fld[CH_W-1 -: BIAS_W];
        gain_q <= fld[GAIN_W:1];
        mode_q <= fld[0];
      end
    end

    assign bias[c*BIAS_W +: BIAS_W] = bias_q;
    assign gain[c*GAIN_W +: GAIN_W] = gain_q;
    assign mode[c]                  = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim    <= TRIM_DEF;
      updated <= 1'b0;
    end else begin
      updated <= commit;
      if (commit) trim <= payload[TRIM_W-1:0];
    end
  end

endmodule

// File: rtl/cfgrx_gain_dec.sv
module cfgrx_gain_dec #(
  parameter int unsigned GAIN_W = 3,
  localparam int unsigned SEL_W = 1 << GAIN_W
) (
  input  logic [GAIN_W-1:0] code,
  output logic [SEL_W-1:0]  sel
);

  always_comb begin
    sel       = '0;
    sel[code] = 1'b1;
  end

endmodule

// File: rtl/cfg_pkt_rx.sv
module cfg_pkt_rx #(
  parameter int unsigned       NUM_CH   = 4,
  parameter int unsigned       BIAS_W   = 4,
  parameter int unsigned       GAIN_W   = 3,
  parameter int unsigned       TRIM_W   = 3,
  parameter int unsigned       HDR_W    = cfgrx_pkg::DEF_HDR_W,
  parameter int unsigned       ADDR_W   = cfgrx_pkg::DEF_ADDR_W,
  parameter logic [HDR_W-1:0]  HDR_PAT  = cfgrx_pkg::DEF_HDR_PAT,
  parameter logic [ADDR_W-1:0] MOD_ADDR = 8'h2A,
  localparam int unsigned CH_W  = BIAS_W + GAIN_W + 1,
  localparam int unsigned PAY_W = NUM_CH * CH_W + TRIM_W,
  localparam int unsigned TAG_W = HDR_W + ADDR_W,
  localparam int unsigned PKT_W = TAG_W + PAY_W,
  localparam int unsigned SEL_W = 1 << GAIN_W
) (
  input  logic                      prog_clk,
  input  logic                      rst_n,
  input  logic                      prog_din,
  output logic [NUM_CH*BIAS_W-1:0]  fe_bias,
  output logic [NUM_CH*GAIN_W-1:0]  pga_gain,
  output logic [NUM_CH-1:0]         rec_spike,
  output logic [NUM_CH*SEL_W-1:0]   pga_sw_sel,
  output logic [TRIM_W-1:0]         cmp_trim,
  output logic                      cfg_updated
);

  logic [PKT_W-1:0] shift_q;
  logic             frame_hit;

  cfgrx_shift #(.WIDTH(PKT_W)) shift_i (
    .clk   (prog_clk),
    .rst_n (rst_n),
    .din   (prog_din),
    .sr    (shift_q)
  );

  // the start pattern and address are the oldest bits once a packet is aligned
  cfgrx_frame_det #(
    .HDR_W    (HDR_W),
    .ADDR_W   (ADDR_W),
    .HDR_PAT  (HDR_PAT),
    .MOD_ADDR (MOD_ADDR)
  ) det_i (
    .tag_bits (shift_q[PKT_W-1 -: TAG_W]),
    .hit      (frame_hit)
  );

  cfgrx_hold #(
    .NUM_CH (NUM_CH),
    .BIAS_W (BIAS_W),
    .GAIN_W (GAIN_W),
    .TRIM_W (TRIM_W)
  ) hold_i (
    .clk     (prog_clk),
    .rst_n   (rst_n),
    .commit  (frame_hit),
    .payload (shift_q[PAY_W-1:0]),
    .bias    (fe_bias),
    .gain    (pga_gain),
    .mode    (rec_spike),
    .trim    (cmp_trim),
    .updated (cfg_updated)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    cfgrx_gain_dec #(.GAIN_W(GAIN_W)) dec_i (
      .code (pga_gain[c*GAIN_W +: GAIN_W]),
      .sel  (pga_sw_sel[c*SEL_W +: SEL_W])
    );
  end

endmodule

// File: rtl/cfgrx_chk.sv
module cfgrx_chk #(
  parameter int unsigned       NUM_CH   = 4,
  parameter int unsigned       BIAS_W   = 4,
  parameter int unsigned       GAIN_W   = 3,
  parameter int unsigned       TRIM_W   = 3,
  parameter int unsigned       HDR_W    = 13,
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [HDR_W-1:0]  HDR_PAT  = 13'b1111100110101,
  parameter logic [ADDR_W-1:0] MOD_ADDR = 8'h2A,
  localparam int unsigned CH_W  = BIAS_W + GAIN_W + 1,
  localparam int unsigned PAY_W = NUM_CH * CH_W + TRIM_W,
  localparam int unsigned PKT_W = HDR_W + ADDR_W + PAY_W,
  localparam int unsigned HIST_W = PKT_W + 1,
  localparam int unsigned SEL_W = 1 << GAIN_W
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      din,
  input logic [NUM_CH*BIAS_W-1:0]  bias,
  input logic [NUM_CH*GAIN_W-1:0]  gain,
  input logic [NUM_CH-1:0]         mode,
  input logic [NUM_CH*SEL_W-1:0]   sel,
  input logic [TRIM_W-1:0]         trim,
  input logic                      updated
);

  // independent record of the pin: one extra bit covers the commit delay
  logic [HIST_W-1:0] hist;
  logic              hist_match;
  logic [PAY_W-1:0]  held_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HIST_W-2:0], din};
  end

  assign hist_match = (hist[HIST_W-1 -: HDR_W] == HDR_PAT) &&
                      (hist[HIST_W-1-HDR_W -: ADDR_W] == MOD_ADDR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign held_pay[PAY_W-1-c*CH_W -: CH_W] =
      {bias[c*BIAS_W +: BIAS_W], gain[c*GAIN_W +: GAIN_W], mode[c]};

    // R6
    gain_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sel[c*SEL_W +: SEL_W]) == 1) &&
      sel[c*SEL_W + int'(gain[c*GAIN_W +: GAIN_W])]);
  end
  assign held_pay[TRIM_W-1:0] = trim;

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updated |-> $stable(held_pay));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated |=> !updated);

  // R3
  commit_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hist_match |-> updated);

  // R4
  no_foreign_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> hist_match);

  // R2
  payload_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    updated |-> (held_pay == hist[PAY_W:1]));

endmodule

bind cfg_pkt_rx cfgrx_chk #(
  .NUM_CH   (NUM_CH),
  .BIAS_W   (BIAS_W),
  .GAIN_W   (GAIN_W),
  .TRIM_W   (TRIM_W),
  .HDR_W    (HDR_W),
  .ADDR_W   (ADDR_W),
  .HDR_PAT  (HDR_PAT),
  .MOD_ADDR (MOD_ADDR)
) chk_i (
  .clk     (prog_clk),
  .rst_n   (rst_n),
  .din     (prog_din),
  .bias    (fe_bias),
  .gain    (pga_gain),
  .mode    (rec_spike),
  .sel     (pga_sw_sel),
  .trim    (cmp_trim),
  .updated (cfg_updated)
);

// File: tb/cfg_pkt_rx_tb_top.sv
module cfg_pkt_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] HDR  = 13'b1111100110101;
  localparam logic [7:0]  ADDR = 8'h2A;
  localparam logic [34:0] DEF_PAY = {8'h81, 8'h81, 8'h81, 8'h81, 3'b100};

  // {accept, start pattern, address, payload}
  localparam logic [56:0] VEC [8] = '{
    {1'b1, HDR,            ADDR,  35'h4_D2C3_B1A5},
    {1'b0, HDR,            8'h2B, 35'h1_2345_6789},
    {1'b0, 13'b1111100110100, ADDR, 35'h7_FFFF_FFFF},
    {1'b1, HDR,            ADDR,  35'h0_0000_0000},
    {1'b1, HDR,            ADDR,  35'h7_FFFF_FFFF},
    {1'b0, 13'b0111100110101, ADDR, 35'h3_0000_0001},
    {1'b1, HDR,            ADDR,  35'h2_468A_CE13},
    {1'b0, HDR,            8'h00, 35'h5_5555_5555}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        din = 1'b0;
  logic [15:0] fe_bias;
  logic [11:0] pga_gain;
  logic [3:0]  rec_spike;
  logic [31:0] pga_sw_sel;
  logic [2:0]  cmp_trim;
  logic        cfg_updated;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  logic [34:0] exp_pay = DEF_PAY;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_pkt_rx dut_i (
    .prog_clk    (clk),
    .rst_n       (rst_n),
    .prog_din    (din),
    .fe_bias     (fe_bias),
    .pga_gain    (pga_gain),
    .rec_spike   (rec_spike),
    .pga_sw_sel  (pga_sw_sel),
    .cmp_trim    (cmp_trim),
    .cfg_updated (cfg_updated)
  );

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic check_outputs(input string tag);
    logic [15:0] eb;
    logic [11:0] eg;
    logic [3:0]  em;
    logic [31:0] es;
    for (int c = 0; c < 4; c++) begin
      eb[c*4 +: 4]  = exp_pay[34-8*c -: 4];
      eg[c*3 +: 3]  = exp_pay[30-8*c -: 3];
      em[c]         = exp_pay[27-8*c];
      es[c*8 +: 8]  = 8'b1 << exp_pay[30-8*c -: 3];
    end
    check(fe_bias === eb,          {tag, " R2 bias"},  64'(fe_bias),    64'(eb));
    check(pga_gain === eg,         {tag, " R2 gain"},  64'(pga_gain),   64'(eg));
    check(rec_spike === em,        {tag, " R2 mode"},  64'(rec_spike),  64'(em));
    check(pga_sw_sel === es,       {tag, " R6 sel"},   64'(pga_sw_sel), 64'(es));
    check(cmp_trim === exp_pay[2:0], {tag, " R2 trim"}, 64'(cmp_trim), 64'(exp_pay[2:0]));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    din = b;
  endtask

  task automatic send_pkt(input logic [55:0] p);
    for (int k = 55; k >= 0; k--) send_bit(p[k]);
  endtask

  // called right after the 56th bit is driven
  task automatic finish_pkt(input logic acc, input logic [34:0] pay, input string tag);
    @(negedge clk);
    check(cfg_updated === 1'b0, {tag, " R3 no early pulse"}, 64'(cfg_updated), 64'd0);
    din = 1'b0;
    @(negedge clk);
    check(cfg_updated === acc, {tag, " pulse"}, 64'(cfg_updated), 64'(acc));
    if (acc) exp_pay = pay;
    check_outputs(tag);
    @(negedge clk);
    check(cfg_updated === 1'b0, {tag, " R3 pulse one cycle"}, 64'(cfg_updated), 64'd0);
    check_outputs({tag, " R7 held"});
  endtask

  function automatic logic [34:0] sweep_pay(input int g);
    logic [34:0] p;
    for (int c = 0; c < 4; c++) begin
      p[34-8*c -: 4] = 4'(g + 3*c);
      p[30-8*c -: 3] = 3'(g + c);
      p[27-8*c]      = 1'((g + c) & 1);
    end
    p[2:0] = 3'(g);
    return p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [55:0] pa;
    logic [55:0] pb;
    repeat (3) @(negedge clk);
    // R1 defaults while reset is applied and after release
    check_outputs("R1 in reset");
    check(cfg_updated === 1'b0, "R1 no pulse in reset", 64'(cfg_updated), 64'd0);
    rst_n = 1'b1;
    repeat (4) send_bit(1'b0);
    check_outputs("R1 after release");

    // table walk: R2 accepted, R4 foreign address, R5 damaged start pattern
    for (int i = 0; i < 8; i++) begin
      logic [55:0] p;
      string       tag;
      p = VEC[i][55:0];
      if (VEC[i][56])               tag = $sformatf("vec%0d R2", i);
      else if (p[55:43] != HDR)     tag = $sformatf("vec%0d R5", i);
      else                          tag = $sformatf("vec%0d R4", i);
      send_pkt(p);
      finish_pkt(VEC[i][56], p[34:0], tag);
    end

    // R6 every gain code on every channel
    for (int g = 0; g < 8; g++) begin
      send_pkt({HDR, ADDR, sweep_pay(g)});
      finish_pkt(1'b1, sweep_pay(g), $sformatf("sweep%0d R6", g));
    end

    // R8 decoy prefix that looks like the start of a start pattern
    for (int k = 10; k >= 0; k--) send_bit(1'(11'b11111001101 >> k));
    send_pkt({HDR, ADDR, 35'h6_1357_9BDF});
    finish_pkt(1'b1, 35'h6_1357_9BDF, "decoy R8");

    // R8 back-to-back packets
    pa = {HDR, ADDR, 35'h3_C3C3_C3C3};
    pb = {HDR, ADDR, 35'h1_0F0F_0F0F};
    send_pkt(pa);
    send_bit(pb[55]);
    @(negedge clk);
    check(cfg_updated === 1'b1, "b2b first R8 pulse", 64'(cfg_updated), 64'd1);
    exp_pay = pa[34:0];
    check_outputs("b2b first R8");
    din = pb[54];
    for (int k = 53; k >= 0; k--) send_bit(pb[k]);
    finish_pkt(1'b1, pb[34:0], "b2b second R8");

    // R9 reset partway through a valid packet
    pa = {HDR, ADDR, 35'h2_2222_2222};
    for (int k = 55; k >= 26; k--) send_bit(pa[k]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    exp_pay = DEF_PAY;
    check_outputs("mid reset R9 R1");
    rst_n = 1'b1;
    for (int k = 25; k >= 0; k--) send_bit(pa[k]);
    finish_pkt(1'b0, pa[34:0], "mid reset R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule